// File: doc/BRIEF.md
# AXI4-Lite Slave to Classic Wishbone Master Bridge

This block sits on the slave side of an AXI4-Lite interconnect. Each read or write it accepts becomes exactly one classic Wishbone master cycle. For a write, the address beat and the data beat may arrive in any order and in cycles far apart. The bridge keeps whichever beat comes first until the other one arrives. It then drives a Wishbone write and, once the slave acknowledges it, returns an OKAY write response. For a read, the bridge latches the address, drives a Wishbone read, captures the slave's data on the acknowledge edge and returns that data on the read data channel.

Only one transaction is handled at a time. Bursts, outstanding transactions, Wishbone error or retry, and protection checking are outside this block. The protection fields and the AXI write strobes are accepted and have no effect. The single Wishbone byte-select bit is driven high on every cycle.

Top module: `lite_wb_bridge`

## Requirements
- R1: While reset is high and in the cycle after it is released, `s_bvalid`, `s_rvalid` and `wb_cyc` are low, and `s_awready`, `s_wready` and `s_arready` are high. Reset is synchronous and active high, and it discards any held beats.
- R2: The write address beat and the write data beat are each accepted on a valid/ready handshake, in either order or in the same cycle. A held beat keeps its ready signal low until it is consumed. No Wishbone cycle starts while only one of the two beats is held.
- R3: Once both write beats are held, `wb_cyc`, `wb_stb`, `wb_sel` and `wb_we` rise together and stay high until `wb_ack` is sampled. During that time `wb_adr` carries the latched write address and `wb_dat_wr` carries the latched write data.
- R4: On the clock edge where `wb_ack` is sampled high, the bridge drops `wb_cyc`, `wb_stb` and `wb_sel`, so they read low in the next cycle.
- R5: The cycle after a Wishbone write is acknowledged, `s_bvalid` is high with `s_bresp` = 2'b00. It holds until `s_bready` is sampled high and reads low in the next cycle.
- R6: An accepted read address starts a Wishbone cycle with `wb_cyc`, `wb_stb` and `wb_sel` high, `wb_we` low, and `wb_adr` equal to the latched read address.
- R7: The cycle after a Wishbone read is acknowledged, `s_rvalid` is high with `s_rresp` = 2'b00 and `s_rdata` equal to the `wb_dat_rd` value sampled at that acknowledge. It holds until `s_rready` is sampled high and reads low in the next cycle.
- R8: `wb_sel` is high in every Wishbone cycle whatever the value of `s_wstrb`. The protection inputs change nothing.
- R9: If a read address and a complete write pair are held at the same time, the Wishbone write is run first and the read follows.
- R10: At most one transaction is in flight. While a Wishbone cycle or a pending response is active, all three address/data ready outputs are low, and no Wishbone cycle overlaps a pending `s_bvalid` or `s_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write address |
| s_awprot | input | 3 | Write protection (ignored) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write strobes (ignored) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read address |
| s_arprot | input | 3 | Read protection (ignored) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code, always OKAY |
| wb_adr | output | ADDR_W | Wishbone address |
| wb_dat_rd | input | DATA_W | Wishbone data from slave |
| wb_dat_wr | output | DATA_W | Wishbone data to slave |
| wb_we | output | 1 | Wishbone write enable |
| wb_sel | output | 1 | Wishbone byte select (single bit) |
| wb_stb | output | 1 | Wishbone strobe |
| wb_ack | input | 1 | Wishbone acknowledge |
| wb_cyc | output | 1 | Wishbone cycle |

## Verification
The embedded assertions check on every cycle that cyc, stb and sel move together and fall right after an acknowledge, and that a held beat keeps its ready low and its value stable. They also check that a response, once raised, is held with an OKAY code until it is taken, that read data equals the value sampled at the acknowledge, and that a Wishbone cycle never overlaps a pending response. Some behaviour only the bench scenarios can show. These are that every AXI transaction produces exactly one Wishbone cycle with the right address, direction and data, in the right order, when the beats arrive in any order or with any gap. They also cover write-over-read priority when both become pending in the same cycle, acknowledge latencies of different lengths, and long back-pressure on either response channel.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WR,
        SQ_RD,
        SQ_BRSP,
        SQ_RRSP
    } sq_state_e;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/lwb_wr_hold.sv
module lwb_wr_hold #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              consume,
    output logic              pair_ok,
    output logic              aw_held,
    output logic              w_held,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    typedef struct packed {
        logic              aw_held;
        logic              w_held;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wh_t;

    wh_t st_d, st_q;

    assign awready = !st_q.aw_held && !busy;
    assign wready  = !st_q.w_held && !busy;
    assign pair_ok = st_q.aw_held && st_q.w_held;
    assign aw_held = st_q.aw_held;
    assign w_held  = st_q.w_held;
    assign addr_q  = st_q.addr;
    assign data_q  = st_q.data;

    always_comb begin
        st_d = st_q;
        if (awvalid && awready) begin
            st_d.aw_held = 1'b1;
            st_d.addr    = awaddr;
        end
        if (wvalid && wready) begin
            st_d.w_held = 1'b1;
            st_d.data   = wdata;
        end
        if (consume) begin
            st_d.aw_held = 1'b0;
            st_d.w_held  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: a held address beat stays put and blocks further acceptance
    assert_aw_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (aw_held && !consume) |=> (aw_held && $stable(addr_q) && !awready));
    assert_w_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (w_held && !consume) |=> (w_held && $stable(data_q) && !wready));

endmodule

// File: rtl/lwb_rd_hold.sv
module lwb_rd_hold #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              busy,
    input  logic              consume,
    output logic              ar_held,
    output logic [ADDR_W-1:0] addr_q
);

    typedef struct packed {
        logic              held;
        logic [ADDR_W-1:0] addr;
    } rh_t;

    rh_t st_d, st_q;

    assign arready = !st_q.held && !busy;
    assign ar_held = st_q.held;
    assign addr_q  = st_q.addr;

    always_comb begin
        st_d = st_q;
        if (arvalid && arready) begin
            st_d.held = 1'b1;
            st_d.addr = araddr;
        end
        if (consume) begin
            st_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: a held read address is not overwritten by a second one
    assert_ar_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (ar_held && !consume) |=> (ar_held && $stable(addr_q) && !arready));

endmodule

// File: rtl/lwb_seq.sv
module lwb_seq
    import lwb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pair_ok,
    input  logic              ar_held,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              wr_consume,
    output logic              rd_consume,
    output logic [ADDR_W-1:0] wb_adr,
    input  logic [DATA_W-1:0] wb_dat_rd,
    output logic [DATA_W-1:0] wb_dat_wr,
    output logic              wb_we,
    output logic              wb_sel,
    output logic              wb_stb,
    input  logic              wb_ack,
    output logic              wb_cyc,
    output logic              bvalid,
    input  logic              bready,
    output logic [1:0]        bresp,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp
);

    typedef struct packed {
        sq_state_e         st;
        logic [DATA_W-1:0] rdata;
    } sq_t;

    sq_t sq_d, sq_q;
    logic in_cycle;

    assign in_cycle   = (sq_q.st == SQ_WR) || (sq_q.st == SQ_RD);
    assign busy       = (sq_q.st != SQ_IDLE);
    assign wb_cyc     = in_cycle;
    assign wb_stb     = in_cycle;
    assign wb_sel     = in_cycle;
    assign wb_we      = (sq_q.st == SQ_WR);
    assign wb_adr     = (sq_q.st == SQ_WR) ? wr_addr : rd_addr;
    assign wb_dat_wr  = wr_data;
    assign wr_consume = (sq_q.st == SQ_WR) && wb_ack;
    assign rd_consume = (sq_q.st == SQ_RD) && wb_ack;
    assign bvalid     = (sq_q.st == SQ_BRSP);
    assign bresp      = RESP_OKAY;
    assign rvalid     = (sq_q.st == SQ_RRSP);
    assign rdata      = sq_q.rdata;
    assign rresp      = RESP_OKAY;

    always_comb begin
        sq_d = sq_q;
        unique case (sq_q.st)
            SQ_IDLE: begin
                if (pair_ok) begin
                    sq_d.st = SQ_WR;
                end else if (ar_held) begin
                    sq_d.st = SQ_RD;
                end
            end
            SQ_WR: begin
                if (wb_ack) sq_d.st = SQ_BRSP;
            end
            SQ_RD: begin
                if (wb_ack) begin
                    sq_d.st    = SQ_RRSP;
                    sq_d.rdata = wb_dat_rd;
                end
            end
            SQ_BRSP: begin
                if (bready) sq_d.st = SQ_IDLE;
            end
            SQ_RRSP: begin
                if (rready) sq_d.st = SQ_IDLE;
            end
            default: sq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_q <= '{st: SQ_IDLE, rdata: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    // R4: the cycle ends right after the acknowledge edge
    assert_cyc_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc && wb_ack) |=> !wb_cyc && !wb_stb && !wb_sel);
    // R3: a cycle without acknowledge keeps its direction and address
    assert_cyc_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc && !wb_ack) |=> (wb_cyc && $stable(wb_we) && $stable(wb_adr)));
    // R5: write response is OKAY and waits for bready
    assert_bvalid_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (bvalid && !bready) |=> (bvalid && bresp == 2'b00));
    assert_bvalid_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (bvalid && bready) |=> !bvalid);
    // R7: read data equals the value sampled at acknowledge
    assert_rdata_R7: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc && !wb_we && wb_ack) |=> (rvalid && rresp == 2'b00 && rdata == $past(wb_dat_rd)));
    assert_rvalid_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));
    // R8: strobe and byte select always accompany the cycle
    assert_sel_R8: assert property (@(posedge clk) disable iff (rst)
        wb_cyc |-> (wb_stb && wb_sel));
    // R9: a complete write pair wins over a held read address
    assert_wr_first_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && pair_ok && ar_held) |=> (wb_cyc && wb_we));
    // R10: no Wishbone cycle overlaps a pending response
    assert_single_R10: assert property (@(posedge clk) disable iff (rst)
        $countones({wb_cyc, bvalid, rvalid}) <= 1);

endmodule

// File: rtl/lite_wb_bridge.sv
module lite_wb_bridge #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic [2:0]          s_awprot,
    input  logic                s_wvalid,
    output logic                s_wready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    output logic                s_bvalid,
    input  logic                s_bready,
    output logic [1:0]          s_bresp,
    input  logic                s_arvalid,
    output logic                s_arready,
    input  logic [ADDR_W-1:0]   s_araddr,
    input  logic [2:0]          s_arprot,
    output logic                s_rvalid,
    input  logic                s_rready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic [ADDR_W-1:0]   wb_adr,
    input  logic [DATA_W-1:0]   wb_dat_rd,
    output logic [DATA_W-1:0]   wb_dat_wr,
    output logic                wb_we,
    output logic                wb_sel,
    output logic                wb_stb,
    input  logic                wb_ack,
    output logic                wb_cyc
);

    logic              busy;
    logic              wr_consume;
    logic              rd_consume;
    logic              pair_ok;
    logic              aw_held;
    logic              w_held;
    logic              ar_held;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic              unused_sideband;

    // sideband fields are accepted and have no effect (R8)
    assign unused_sideband = ^{s_awprot, s_arprot, s_wstrb};

    lwb_wr_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr_hold (
        .clk     (clk),
        .rst     (rst),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .awaddr  (s_awaddr),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .wdata   (s_wdata),
        .busy    (busy),
        .consume (wr_consume),
        .pair_ok (pair_ok),
        .aw_held (aw_held),
        .w_held  (w_held),
        .addr_q  (wr_addr),
        .data_q  (wr_data)
    );

    lwb_rd_hold #(.ADDR_W(ADDR_W)) u_rd_hold (
        .clk     (clk),
        .rst     (rst),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .araddr  (s_araddr),
        .busy    (busy),
        .consume (rd_consume),
        .ar_held (ar_held),
        .addr_q  (rd_addr)
    );

    lwb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pair_ok    (pair_ok),
        .ar_held    (ar_held),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .busy       (busy),
        .wr_consume (wr_consume),
        .rd_consume (rd_consume),
        .wb_adr     (wb_adr),
        .wb_dat_rd  (wb_dat_rd),
        .wb_dat_wr  (wb_dat_wr),
        .wb_we      (wb_we),
        .wb_sel     (wb_sel),
        .wb_stb     (wb_stb),
        .wb_ack     (wb_ack),
        .wb_cyc     (wb_cyc),
        .bvalid     (s_bvalid),
        .bready     (s_bready),
        .bresp      (s_bresp),
        .rvalid     (s_rvalid),
        .rready     (s_rready),
        .rdata      (s_rdata),
        .rresp      (s_rresp)
    );

    // R2: no Wishbone cycle starts from a single write beat
    assert_half_pair_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && (aw_held != w_held) && !ar_held) |=> !wb_cyc);
    // R10: all address/data ready outputs are low while busy
    assert_ready_busy_R10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(s_awready || s_wready || s_arready));

endmodule

// File: tb/lite_wb_bridge_tb.sv
module lite_wb_bridge_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 32;

    typedef struct {
        bit          rd;
        logic [AW-1:0] adr;
        logic [DW-1:0] dat;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic s_awvalid = 1'b0, s_awready;
    logic [AW-1:0] s_awaddr = '0;
    logic [2:0] s_awprot = 3'd0;
    logic s_wvalid = 1'b0, s_wready;
    logic [DW-1:0] s_wdata = '0;
    logic [DW/8-1:0] s_wstrb = '0;
    logic s_bvalid, s_bready = 1'b1;
    logic [1:0] s_bresp;
    logic s_arvalid = 1'b0, s_arready;
    logic [AW-1:0] s_araddr = '0;
    logic [2:0] s_arprot = 3'd0;
    logic s_rvalid, s_rready = 1'b1;
    logic [DW-1:0] s_rdata;
    logic [1:0] s_rresp;
    logic [AW-1:0] wb_adr;
    logic [DW-1:0] wb_dat_rd = '0;
    logic [DW-1:0] wb_dat_wr;
    logic wb_we, wb_sel, wb_stb, wb_cyc;
    logic wb_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int ack_lat = 0;
    int lat_cnt = 0;
    bit done = 0;
    item_t sbq[$];
    item_t rspq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lite_wb_bridge #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awprot(s_awprot),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr), .s_arprot(s_arprot),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .wb_adr(wb_adr), .wb_dat_rd(wb_dat_rd), .wb_dat_wr(wb_dat_wr), .wb_we(wb_we),
        .wb_sel(wb_sel), .wb_stb(wb_stb), .wb_ack(wb_ack), .wb_cyc(wb_cyc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rdval(input logic [AW-1:0] a);
        return {a, ~a, a, 8'h5A} ^ 32'h3C00_0000;
    endfunction

    // Wishbone slave model plus scoreboard monitor for the request side
    always @(negedge clk) begin
        if (wb_ack) begin
            wb_ack = 1'b0;
            lat_cnt = 0;
            chk(!wb_cyc && !wb_stb && !wb_sel, "R4", "cycle after ack", {wb_cyc, wb_stb, wb_sel}, 0);
        end else if (wb_cyc && !rst) begin
            if (lat_cnt >= ack_lat) begin
                item_t e;
                chk(wb_stb && wb_sel, "R8", "stb/sel during cycle", {wb_stb, wb_sel}, 3);
                chk(!s_awready && !s_wready && !s_arready, "R10", "readies low while busy",
                    {s_awready, s_wready, s_arready}, 0);
                chk(!s_bvalid && !s_rvalid, "R10", "no response during cycle", {s_bvalid, s_rvalid}, 0);
                if (sbq.size() == 0) begin
                    chk(0, "R10", "unexpected Wishbone cycle", wb_adr, 0);
                end else begin
                    e = sbq.pop_front();
                    chk(wb_we == !e.rd, e.rd ? "R6" : "R3", "direction", wb_we, !e.rd);
                    chk(wb_adr == e.adr, e.rd ? "R6" : "R3", "address", wb_adr, e.adr);
                    if (!e.rd) begin
                        chk(wb_dat_wr == e.dat, "R3", "write data", wb_dat_wr, e.dat);
                        rspq.push_back('{rd: 0, adr: e.adr, dat: '0});
                    end else begin
                        wb_dat_rd = rdval(e.adr);
                        rspq.push_back('{rd: 1, adr: e.adr, dat: rdval(e.adr)});
                    end
                end
                wb_ack = 1'b1;
            end else begin
                lat_cnt++;
            end
        end
    end

    // response-side monitor
    always @(negedge clk) begin
        if (!rst && ((s_bvalid && s_bready) || (s_rvalid && s_rready))) begin
            item_t e;
            if (rspq.size() == 0) begin
                chk(0, "R10", "unexpected response", {s_bvalid, s_rvalid}, 0);
            end else begin
                e = rspq.pop_front();
                if (!e.rd) begin
                    chk(s_bvalid && !s_rvalid, "R5", "write response kind", {s_bvalid, s_rvalid}, 2);
                    chk(s_bresp == 2'b00, "R5", "bresp", s_bresp, 0);
                end else begin
                    chk(s_rvalid && !s_bvalid, "R7", "read response kind", {s_bvalid, s_rvalid}, 1);
                    chk(s_rresp == 2'b00, "R7", "rresp", s_rresp, 0);
                    chk(s_rdata == e.dat, "R7", "rdata", s_rdata, e.dat);
                end
            end
        end
    end

    task automatic send_aw(input logic [AW-1:0] a);
        bit got = 0;
        @(posedge clk); #2;
        s_awvalid = 1'b1; s_awaddr = a; s_awprot = 3'b101;
        while (!got) begin @(negedge clk); got = s_awready; end
        @(posedge clk); #2;
        s_awvalid = 1'b0; s_awaddr = ~a;
    endtask

    task automatic send_w(input logic [DW-1:0] d, input logic [DW/8-1:0] s);
        bit got = 0;
        @(posedge clk); #2;
        s_wvalid = 1'b1; s_wdata = d; s_wstrb = s;
        while (!got) begin @(negedge clk); got = s_wready; end
        @(posedge clk); #2;
        s_wvalid = 1'b0; s_wdata = ~d;
    endtask

    task automatic send_ar(input logic [AW-1:0] a);
        bit got = 0;
        @(posedge clk); #2;
        s_arvalid = 1'b1; s_araddr = a; s_arprot = 3'b011;
        while (!got) begin @(negedge clk); got = s_arready; end
        @(posedge clk); #2;
        s_arvalid = 1'b0; s_araddr = ~a;
    endtask

    // driver: push expected item, then drive the AXI beats
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [DW/8-1:0] s, input int mode);
        sbq.push_back('{rd: 0, adr: a, dat: d});
        if (mode == 0) begin
            send_aw(a);
            @(negedge clk);
            chk(!s_awready && s_wready, "R2", "aw held, w open", {s_awready, s_wready}, 1);
            repeat (3) begin
                @(negedge clk);
                chk(!wb_cyc, "R2", "no cycle on half pair", wb_cyc, 0);
            end
            send_w(d, s);
        end else if (mode == 1) begin
            send_w(d, s);
            @(negedge clk);
            chk(!s_wready && s_awready, "R2", "w held, aw open", {s_awready, s_wready}, 2);
            repeat (2) begin
                @(negedge clk);
                chk(!wb_cyc, "R2", "no cycle on half pair", wb_cyc, 0);
            end
            send_aw(a);
        end else begin
            fork
                send_aw(a);
                send_w(d, s);
            join
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        sbq.push_back('{rd: 1, adr: a, dat: '0});
        send_ar(a);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (sbq.size() == 0 && rspq.size() == 0 && !wb_cyc && !s_bvalid && !s_rvalid) break;
        end
        chk(sbq.size() == 0 && rspq.size() == 0, "R10", "all items drained", sbq.size() + rspq.size(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        chk(0, "R10", "watchdog expired", 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        @(negedge clk);
        chk(!s_bvalid && !s_rvalid && !wb_cyc, "R1", "outputs in reset", {s_bvalid, s_rvalid, wb_cyc}, 0);
        @(posedge clk); #2; rst = 1'b0;
        @(negedge clk);
        chk(!s_bvalid && !s_rvalid && !wb_cyc, "R1", "outputs after reset", {s_bvalid, s_rvalid, wb_cyc}, 0);
        chk(s_awready && s_wready && s_arready, "R1", "readies after reset",
            {s_awready, s_wready, s_arready}, 7);

        // R2/R3: address first with a gap, zero strobes (R8)
        ack_lat = 0;
        do_write(8'h0C, 32'hDEAD_BEEF, 4'b0000, 0);
        wait_idle();
        // R2: data first
        ack_lat = 2;
        do_write(8'hA1, 32'h1234_5678, 4'b1111, 1);
        wait_idle();
        // both beats together
        ack_lat = 1;
        do_write(8'h7E, 32'h0F0F_A5A5, 4'b0101, 2);
        wait_idle();

        // R6/R7: reads with different latencies
        ack_lat = 0;
        do_read(8'h0D);
        wait_idle();
        ack_lat = 4;
        do_read(8'hF3);
        wait_idle();

        // R5: write response back-pressure
        s_bready = 1'b0;
        ack_lat = 1;
        do_write(8'h33, 32'hCAFE_0001, 4'b1000, 2);
        for (int i = 0; i < 40 && !s_bvalid; i++) @(negedge clk);
        repeat (4) begin
            @(negedge clk);
            chk(s_bvalid && s_bresp == 2'b00, "R5", "bvalid held", {s_bvalid, s_bresp}, 4);
            chk(!s_awready && !s_arready, "R10", "readies low while response pending",
                {s_awready, s_arready}, 0);
        end
        @(posedge clk); #2; s_bready = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(!s_bvalid, "R5", "bvalid cleared after bready", s_bvalid, 0);
        wait_idle();

        // R7: read response back-pressure
        s_rready = 1'b0;
        ack_lat = 0;
        do_read(8'h44);
        for (int i = 0; i < 40 && !s_rvalid; i++) @(negedge clk);
        repeat (3) begin
            @(negedge clk);
            chk(s_rvalid && s_rdata == rdval(8'h44), "R7", "rvalid/rdata held", s_rdata, rdval(8'h44));
        end
        @(posedge clk); #2; s_rready = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(!s_rvalid, "R7", "rvalid cleared after rready", s_rvalid, 0);
        wait_idle();

        // R9: read and complete write pair pending together: write first
        ack_lat = 1;
        sbq.push_back('{rd: 0, adr: 8'h55, dat: 32'hB0B0_C1C1});
        sbq.push_back('{rd: 1, adr: 8'h66, dat: '0});
        fork
            send_aw(8'h55);
            send_w(32'hB0B0_C1C1, 4'b1111);
            send_ar(8'h66);
        join
        wait_idle();

        // back-to-back mixed traffic
        for (int k = 0; k < 4; k++) begin
            ack_lat = k;
            do_write(AW'(8'h10 + k), 32'h9000_0000 + k, 4'b0011, k % 3);
            do_read(AW'(8'h20 + k));
        end
        wait_idle();

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule